// File: doc/BRIEF.md
# Bus-Mapped Asynchronous Serial Port with Interrupt Events

This block is a memory-mapped serial port that sits on a 32-bit Wishbone slave port. Software programs how many clock cycles one serial bit lasts. It can hand over one byte at a time for transmission and collect one received byte at a time. Separate registers report whether a byte is waiting, whether the last frame ended badly, and whether the transmitter can take a new byte.

A small event unit tracks the "byte received" condition. It latches each new arrival as pending. Software can mask the pending event, and it clears the event by writing a one to it. The result drives a single level-sensitive interrupt line. The serial side has one output line and one input line. The block works with the two lines tied together, so a byte written for transmission comes back as a received byte.

Top module: `serial_port_wb`

## Requirements
- R1: Registers are reached by word address, which is the byte offset divided by four. The word addresses are: 0 bit-period divisor (read/write), 1 received byte (read), 2 receive-ready flag in bit 0, 3 frame-error flag in bit 0, 4 transmit byte (write), 5 transmit-ready flag in bit 0, 8 event source status, 9 event pending, 10 event enable. A write takes effect only when all four byte selects are set.
- R2: Each strobed bus cycle is answered with an ack that is high for exactly one clock. A read of any address not listed in R1 (for example 6) returns zero.
- R3: The divisor resets to the DIV_RESET parameter, which defaults to 5. It is writable and reads back the value written. Every serial bit lasts exactly that many clock cycles. Divisor values below 2 are not supported.
- R4: The output line idles high. A frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit.
- R5: Transmit-ready reads 1 when the transmitter is idle and 0 while a frame is going out. A write to the transmit byte while it is not ready is dropped, and no frame is produced for it.
- R6: The receiver starts timing at a falling edge on the input and samples each bit in the middle of its period. After the stop bit it sets receive-ready and holds the byte at word address 1. In loopback the received byte equals the byte that was sent.
- R7: Reading the received byte clears receive-ready.
- R8: The frame-error flag is updated at the end of every frame. It reads 1 if the stop bit was sampled low and 0 if it was sampled high. The data byte is captured in both cases.
- R9: Event bit 0 is the receive-ready event. The status register shows receive-ready. A pending bit is set when its source rises, and it stays set until a 1 is written to that bit of the pending register.
- R10: The interrupt output is high exactly when some bit is set in both the pending and the enable registers. While enable is 0, a new arrival still sets pending but leaves the interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 4 | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_sel_i | input | 4 | Byte selects |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| irq_o | output | 1 | Level interrupt |
| rx_i | input | 1 | Serial input line |
| tx_o | output | 1 | Serial output line |

## Verification
Bytes 0xAB, 0x5A, 0x01, 0x96 and 0x3C are sent, so the tests use both alternating and sparse bit patterns. A swapped bit order or a shifted sampling point therefore changes the decoded value. Frames are run at divisors 5 and 8, and an independent line decoder times each bit, so an off-by-one in the bit period is caught. A write issued while the transmitter is busy shows that the write is dropped and not queued. Frames driven by hand with a low stop bit and then a high stop bit show that the error flag follows the stop bit. A frame received with the event masked shows that pending and the interrupt are separate.

// File: rtl/serial_pkg.sv
package serial_pkg;
  localparam int ADR_W      = 4;
  localparam int BUS_W      = 32;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = BYTE_W + 2;
  localparam int BITCNT_W   = $clog2(FRAME_BITS);

  localparam logic [ADR_W-1:0] A_DIV    = 4'd0;
  localparam logic [ADR_W-1:0] A_RXDATA = 4'd1;
  localparam logic [ADR_W-1:0] A_RXRDY  = 4'd2;
  localparam logic [ADR_W-1:0] A_RXERR  = 4'd3;
  localparam logic [ADR_W-1:0] A_TXDATA = 4'd4;
  localparam logic [ADR_W-1:0] A_TXRDY  = 4'd5;
  localparam logic [ADR_W-1:0] A_EVSTAT = 4'd8;
  localparam logic [ADR_W-1:0] A_EVPEND = 4'd9;
  localparam logic [ADR_W-1:0] A_EVEN   = 4'd10;
endpackage

// File: rtl/ser_tx.sv
module ser_tx
  import serial_pkg::*;
#(
  parameter int DIV_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              start,
  input  logic [BYTE_W-1:0] data,
  output logic              ready,
  output logic              tx
);
  logic                  busy_q, busy_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [BITCNT_W-1:0]   bit_q, bit_d;
  logic [DIV_W-1:0]      cnt_q, cnt_d;
  logic                  tx_q, tx_d;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, data, 1'b0};
        bit_d  = '0;
        cnt_d  = divisor - 1'b1;
      end
    end else if (cnt_q == '0) begin
      if (bit_q == BITCNT_W'(FRAME_BITS - 1)) begin
        busy_d = 1'b0;
      end else begin
        sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
        bit_d = bit_q + 1'b1;
        cnt_d = divisor - 1'b1;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    tx_d = busy_d ? sh_d[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      bit_q  <= '0;
      cnt_q  <= '0;
      tx_q   <= 1'b1;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
      tx_q   <= tx_d;
    end
  end

  assign ready = ~busy_q;
  assign tx    = tx_q;
endmodule

// File: rtl/ser_rx.sv
module ser_rx
  import serial_pkg::*;
#(
  parameter int DIV_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              rx,
  output logic              done,
  output logic [BYTE_W-1:0] data,
  output logic              frame_err
);
  logic                 s1_q, s2_q, prev_q;
  logic                 act_q, act_d;
  logic [BITCNT_W-1:0]  bit_q, bit_d;
  logic [DIV_W-1:0]     cnt_q, cnt_d;
  logic [BYTE_W-1:0]    sh_q, sh_d;
  logic                 done_q, done_d;
  logic                 err_q, err_d;

  always_comb begin
    act_d  = act_q;
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    err_d  = err_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (prev_q && !s2_q) begin
        act_d = 1'b1;
        bit_d = '0;
        cnt_d = (divisor >> 1) - 1'b1;
      end
    end else if (cnt_q == '0) begin
      cnt_d = divisor - 1'b1;
      if (bit_q == '0) begin
        if (s2_q) act_d = 1'b0;
        else      bit_d = bit_q + 1'b1;
      end else if (bit_q == BITCNT_W'(FRAME_BITS - 1)) begin
        act_d  = 1'b0;
        done_d = 1'b1;
        err_d  = ~s2_q;
      end else begin
        sh_d  = {s2_q, sh_q[BYTE_W-1:1]};
        bit_d = bit_q + 1'b1;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      act_q  <= 1'b0;
      bit_q  <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      s1_q   <= rx;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      act_q  <= act_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign done      = done_q;
  assign data      = sh_q;
  assign frame_err = err_q;
endmodule

// File: rtl/ser_events.sv
module ser_events #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic         pend_we,
  input  logic         en_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] pending,
  output logic [N-1:0] enable,
  output logic         irq
);
  logic [N-1:0] src_q, pend_q, pend_d, en_q, en_d;

  always_comb begin
    pend_d = pend_q & ~(pend_we ? wdata : '0);
    pend_d = pend_d | (src & ~src_q);
    en_d   = en_we ? wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      src_q  <= src;
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  assign pending = pend_q;
  assign enable  = en_q;
  assign irq     = |(pend_q & en_q);
endmodule

// File: rtl/serial_port_wb.sv
module serial_port_wb
  import serial_pkg::*;
#(
  parameter int                DIV_W     = 32,
  parameter logic [DIV_W-1:0]  DIV_RESET = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [ADR_W-1:0] wb_adr_i,
  input  logic [BUS_W-1:0] wb_dat_i,
  input  logic [3:0]       wb_sel_i,
  output logic [BUS_W-1:0] wb_dat_o,
  output logic             wb_ack_o,
  output logic             irq_o,
  input  logic             rx_i,
  output logic             tx_o
);
  localparam int NEV = 1;

  logic [1:0]        rsync_q;
  logic              rst_int;
  logic              ack_q;
  logic [BUS_W-1:0]  dat_q, rdata;
  logic              req, wr, rd;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              rx_ready_q, rx_ready_d;
  logic              rx_err_q, rx_err_d;
  logic [BYTE_W-1:0] rx_byte_q, rx_byte_d;
  logic              tx_ready, tx_start;
  logic              rx_done, rx_ferr;
  logic [BYTE_W-1:0] rx_word;
  logic [NEV-1:0]    ev_pending, ev_enable;

  // Reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int = rsync_q[1];

  assign req = wb_cyc_i & wb_stb_i & ~ack_q;
  assign wr  = req & wb_we_i & (&wb_sel_i);
  assign rd  = req & ~wb_we_i;

  assign tx_start = wr && (wb_adr_i == A_TXDATA);

  ser_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_int), .divisor(div_q), .start(tx_start),
    .data(wb_dat_i[BYTE_W-1:0]), .ready(tx_ready), .tx(tx_o)
  );

  ser_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_int), .divisor(div_q), .rx(rx_i),
    .done(rx_done), .data(rx_word), .frame_err(rx_ferr)
  );

  ser_events #(.N(NEV)) u_ev (
    .clk(clk), .rst_n(rst_int), .src(rx_ready_q),
    .pend_we(wr && (wb_adr_i == A_EVPEND)),
    .en_we(wr && (wb_adr_i == A_EVEN)),
    .wdata(wb_dat_i[NEV-1:0]),
    .pending(ev_pending), .enable(ev_enable), .irq(irq_o)
  );

  always_comb begin
    div_d      = (wr && wb_adr_i == A_DIV) ? wb_dat_i[DIV_W-1:0] : div_q;
    rx_ready_d = rx_ready_q;
    if (rd && wb_adr_i == A_RXDATA) rx_ready_d = 1'b0;
    if (rx_done)                    rx_ready_d = 1'b1;
    rx_err_d  = rx_done ? rx_ferr : rx_err_q;
    rx_byte_d = rx_done ? rx_word : rx_byte_q;
    case (wb_adr_i)
      A_DIV:    rdata = BUS_W'(div_q);
      A_RXDATA: rdata = BUS_W'(rx_byte_q);
      A_RXRDY:  rdata = BUS_W'(rx_ready_q);
      A_RXERR:  rdata = BUS_W'(rx_err_q);
      A_TXRDY:  rdata = BUS_W'(tx_ready);
      A_EVSTAT: rdata = BUS_W'(rx_ready_q);
      A_EVPEND: rdata = BUS_W'(ev_pending);
      A_EVEN:   rdata = BUS_W'(ev_enable);
      default:  rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      ack_q      <= 1'b0;
      dat_q      <= '0;
      div_q      <= DIV_RESET;
      rx_ready_q <= 1'b0;
      rx_err_q   <= 1'b0;
      rx_byte_q  <= '0;
    end else begin
      ack_q      <= req;
      dat_q      <= rd ? rdata : '0;
      div_q      <= div_d;
      rx_ready_q <= rx_ready_d;
      rx_err_q   <= rx_err_d;
      rx_byte_q  <= rx_byte_d;
    end
  end

  assign wb_ack_o = ack_q;
  assign wb_dat_o = dat_q;
endmodule

// File: rtl/serial_port_wb_chk.sv
module serial_port_wb_chk
  import serial_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cyc,
  input logic             stb,
  input logic             we,
  input logic [ADR_W-1:0] adr,
  input logic [3:0]       sel,
  input logic             wdat0,
  input logic             ack,
  input logic [BUS_W-1:0] dat_o,
  input logic             tx,
  input logic             tx_ready,
  input logic             rx_done,
  input logic             rx_ready,
  input logic             pend0
);
  logic strobe;
  assign strobe = cyc & stb & ~ack;

  // R2: ack lasts a single cycle
  p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R2: unmapped reads return zero
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(!we && (adr == 4'd6 || adr == 4'd7 || adr > 4'd10)))
      |-> dat_o == '0);

  // R4: line is high whenever the transmitter is idle
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx);

  // R5: accepted transmit write makes the transmitter busy
  p_tx_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && we && (&sel) && adr == 4'd4 && tx_ready) |=> !tx_ready);

  // R6: frame completion raises receive-ready
  p_rx_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_ready);

  // R9: pending holds until written with one
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend0 && !(strobe && we && (&sel) && adr == 4'd9 && wdat0)) |=> pend0);
endmodule

bind serial_port_wb serial_port_wb_chk u_chk (
  .clk(clk), .rst_n(rst_int), .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i),
  .adr(wb_adr_i), .sel(wb_sel_i), .wdat0(wb_dat_i[0]), .ack(wb_ack_o),
  .dat_o(wb_dat_o), .tx(tx_o), .tx_ready(tx_ready), .rx_done(rx_done),
  .rx_ready(rx_ready_q), .pend0(ev_pending[0])
);

// File: tb/tb_serial_port_wb.sv
module tb_serial_port_wb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [3:0]  adr = '0;
  logic [31:0] wdat = '0;
  logic [3:0]  sel = 4'hf;
  logic [31:0] rdat;
  logic        ack, irq, tx_line, rx_line;
  logic        loop_en = 1'b1;
  logic        drv_rx = 1'b1;
  int          cur_div = 5;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;
  logic [7:0]  exp_q[$];

  always #10 clk = ~clk;

  assign rx_line = loop_en ? tx_line : drv_rx;

  serial_port_wb dut (
    .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_sel_i(sel), .wb_dat_o(rdat),
    .wb_ack_o(ack), .irq_o(irq), .rx_i(rx_line), .tx_o(tx_line)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] r, input bit chk_ack);
    @(posedge clk); #1;
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    do begin @(posedge clk); #1; end while (!ack);
    r = rdat;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(posedge clk); #1;
    if (chk_ack) check("R2 ack single cycle", {31'd0, ack}, 32'd0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] r;
    bus(1'b1, a, d, r, 1'b0);
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] r;
    bus(1'b0, a, 32'd0, r, 1'b0);
    check(req, r, exp);
  endtask

  // driver: record the expected frame, then write it
  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    wr(4'd4, {24'd0, b});
  endtask

  task automatic wait_rx(input string req);
    logic [31:0] r;
    int n = 0;
    do begin
      bus(1'b0, 4'd2, 32'd0, r, 1'b0);
      n++;
    end while (r[0] !== 1'b1 && n < 200);
    check(req, {31'd0, r[0]}, 32'd1);
  endtask

  task automatic drive_frame(input logic [7:0] b, input logic stopbit);
    logic [9:0] f;
    f = {stopbit, b, 1'b0};
    @(posedge clk); #1;
    for (int i = 0; i < 10; i++) begin
      drv_rx = f[i];
      repeat (cur_div) @(posedge clk);
      #1;
    end
    drv_rx = 1'b1;
  endtask

  // monitor: decode the line and compare with the expected queue (R3, R4)
  initial begin
    logic [7:0] got;
    logic st, sp;
    int d;
    forever begin
      @(negedge tx_line);
      d = cur_div;
      repeat (d / 2) @(posedge clk);
      #1; st = tx_line;
      for (int i = 0; i < 8; i++) begin
        repeat (d) @(posedge clk);
        #1; got[i] = tx_line;
      end
      repeat (d) @(posedge clk);
      #1; sp = tx_line;
      check("R4 start bit low", {31'd0, st}, 32'd0);
      check("R4 stop bit high", {31'd0, sp}, 32'd1);
      if (exp_q.size() == 0) begin
        check("R5 unexpected frame", {24'd0, got}, 32'hffff_ffff);
      end else begin
        check("R3 R4 decoded frame", {24'd0, got}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check("R4 idle line", {31'd0, tx_line}, 32'd1);
    check("R10 irq at reset", {31'd0, irq}, 32'd0);
    bus(1'b0, 4'd0, 32'd0, r, 1'b1);
    check("R3 R1 divisor reset", r, 32'd5);
    rdchk("R5 tx ready idle", 4'd5, 32'd1);
    rdchk("R6 rx ready reset", 4'd2, 32'd0);
    rdchk("R2 unmapped read", 4'd6, 32'd0);
    rdchk("R2 unmapped read high", 4'd15, 32'd0);

    // loopback at divisor 5
    wr(4'd10, 32'd1);
    rdchk("R9 enable readback", 4'd10, 32'd1);
    send_byte(8'hAB);
    rdchk("R5 tx busy", 4'd5, 32'd0);
    wait_rx("R6 rx ready after frame");
    check("R10 irq enabled", {31'd0, irq}, 32'd1);
    rdchk("R9 pending set", 4'd9, 32'd1);
    rdchk("R9 status", 4'd8, 32'd1);
    rdchk("R6 loopback byte", 4'd1, 32'hAB);
    rdchk("R7 ready cleared by read", 4'd2, 32'd0);
    rdchk("R8 good stop", 4'd3, 32'd0);
    check("R10 irq held by pending", {31'd0, irq}, 32'd1);
    wr(4'd9, 32'd1);
    check("R10 irq after clear", {31'd0, irq}, 32'd0);
    rdchk("R9 pending cleared", 4'd9, 32'd0);

    // divisor 8, write while busy
    wr(4'd0, 32'd8);
    cur_div = 8;
    rdchk("R3 divisor readback", 4'd0, 32'd8);
    send_byte(8'h5A);
    wr(4'd4, 32'hC3);
    wait_rx("R6 rx ready div 8");
    rdchk("R6 byte div 8", 4'd1, 32'h5A);
    repeat (120) @(posedge clk);
    #1;
    rdchk("R5 busy write dropped", 4'd2, 32'd0);
    wr(4'd9, 32'd1);

    // masked event
    wr(4'd10, 32'd0);
    send_byte(8'h01);
    wait_rx("R6 rx ready masked");
    check("R10 irq masked", {31'd0, irq}, 32'd0);
    rdchk("R10 pending while masked", 4'd9, 32'd1);
    rdchk("R6 byte 01", 4'd1, 32'h01);
    wr(4'd9, 32'd1);

    // hand-driven frames
    loop_en = 1'b0;
    drive_frame(8'h96, 1'b0);
    repeat (8) @(posedge clk);
    wait_rx("R8 ready on bad stop");
    rdchk("R8 error on low stop", 4'd3, 32'd1);
    rdchk("R8 data on bad stop", 4'd1, 32'h96);
    repeat (16) @(posedge clk);
    drive_frame(8'h3C, 1'b1);
    wait_rx("R8 ready on good stop");
    rdchk("R8 error cleared", 4'd3, 32'd0);
    rdchk("R6 byte 3C", 4'd1, 32'h3C);

    check("R4 all frames seen", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule